// File: doc/BRIEF.md
# BCD Calendar Clock Counter

This block keeps wall-clock time and date in packed BCD: seconds, minutes, hours, day of month, month, a two-digit year and a day-of-week index. It advances once per pulse on a 1 Hz enable input. The carry from one field into the next is resolved one field per clock cycle, and a busy output stays high while that ripple is in progress. Hours are kept either in a 24-hour format or in a 12-hour format with a separate afternoon flag. The format is chosen by a bit in a control register.

Software reads and writes every field through a small byte-wide register port. To read a coherent snapshot while the clock runs, software raises the hold input and waits for busy to fall. It then reads or writes freely and releases hold. Any seconds that elapsed while hold was high are folded into a single deferred advance. Counter and control storage is deliberately left uninitialised by reset, so software must load every field after power-up. After changing the hour format, software must also rewrite the hour and date fields.

Day rollover uses the length of the current month, with February lengthened in years whose two-digit value is divisible by four. A day number that does not exist in its month still rolls over to the first of the following month.

Top module: `bcd_calendar_clock`

## Requirements
- R1: Seconds and minutes count in BCD from 0x00 to 0x59. On the advance after 0x59 a field returns to 0x00 and carries into the next field.
- R2: With control bit 0 set (24-hour format), hours count 0x00 to 0x23. The advance after 0x23 gives 0x00 and carries into the day.
- R3: With control bit 0 clear (12-hour format), hours count 0x01 to 0x12, and hour-register bit 6 is the afternoon flag. The step 11 to 12 toggles that flag, and the step 12 to 1 leaves it unchanged. A day carry occurs when the flag goes from 1 to 0.
- R4: On a day carry, a day whose binary value is at or above the month length becomes 0x01 and carries into the month; otherwise the day increments in BCD. Months 4, 6, 9 and 11 have 30 days. Month 2 has 29 days when the binary year is divisible by 4 and 28 days otherwise. All other months have 31 days. Out-of-calendar days such as April 31 therefore roll to the 1st of the next month.
- R5: Month 0x12 advances to 0x01 and carries into the year. Year 0x99 advances to 0x00.
- R6: The weekday counts 0 to 6, steps once on every day carry, and wraps from 6 to 0.
- R7: After an accepted 1 Hz pulse, busy rises at the next clock edge. It stays high for exactly one cycle per field the carry reaches (1 for seconds only, up to 6 when the year advances), then falls.
- R8: A register write presented while busy is high has no effect on any field.
- R9: While hold is high and busy is low, no field advances and busy stays low. One or more pulses that arrive during hold produce exactly one advance after hold falls.
- R10: Reset clears the ripple sequencer and the deferred-advance flag, so busy reads 0 after reset. Counter and control contents are not changed by reset.
- R11: Register addresses are 0 seconds, 1 minutes, 2 hours (bit 6 afternoon flag), 3 day, 4 month, 5 year, 6 weekday, 7 control (bit 0 selects 24-hour format). Reads are combinational from rd_addr, and unused bits read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset of the sequencer |
| tick_1hz | input | 1 | One-cycle pulse once per second |
| hold | input | 1 | Freezes the start of new advances |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Register read data |
| busy | output | 1 | High while a carry ripples through the fields |

## Verification
Four properties are checked on every cycle:
- no ripple starts while hold is high;
- an accepted pulse raises busy on the next edge;
- the seconds field never moves while idle without a write, and the control bit never moves under a write blocked by busy;
- a ripple never lasts beyond six cycles.

The bench scenarios cover what those properties cannot show: the arithmetic of every rollover, the 12-hour afternoon sequence, month lengths across leap and common years, out-of-calendar days, the exact busy length for each carry depth, and the single deferred advance after hold.

// File: rtl/calclk_pkg.sv
package calclk_pkg;

    localparam int ADDR_W = 3;
    localparam int DATA_W = 8;
    localparam int MAX_RIPPLE = 6;

    localparam logic [ADDR_W-1:0] A_SEC  = 3'd0;
    localparam logic [ADDR_W-1:0] A_MIN  = 3'd1;
    localparam logic [ADDR_W-1:0] A_HOUR = 3'd2;
    localparam logic [ADDR_W-1:0] A_DAY  = 3'd3;
    localparam logic [ADDR_W-1:0] A_MON  = 3'd4;
    localparam logic [ADDR_W-1:0] A_YEAR = 3'd5;
    localparam logic [ADDR_W-1:0] A_WDAY = 3'd6;
    localparam logic [ADDR_W-1:0] A_CTRL = 3'd7;

    typedef enum logic [2:0] {
        ST_IDLE, ST_SEC, ST_MIN, ST_HOUR, ST_DAY, ST_MON, ST_YEAR
    } stage_e;

    typedef struct packed {
        logic [6:0] sec;
        logic [6:0] min;
        logic       pm;
        logic [5:0] hour;
        logic [5:0] day;
        logic [4:0] mon;
        logic [7:0] year;
        logic [2:0] wday;
    } cal_t;

    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        logic [7:0] r;
        if (v[3:0] == 4'd9) begin
            r = {v[7:4] + 4'd1, 4'd0};
        end else begin
            r = {v[7:4], v[3:0] + 4'd1};
        end
        return r;
    endfunction

    function automatic logic [6:0] bcd2bin(input logic [7:0] v);
        return 7'({3'd0, v[7:4]} * 7'd10 + {3'd0, v[3:0]});
    endfunction

    function automatic logic [6:0] month_len(input logic [4:0] mon_bcd, input logic [7:0] yr_bcd);
        logic [6:0] m;
        logic [6:0] y;
        m = bcd2bin({3'd0, mon_bcd});
        y = bcd2bin(yr_bcd);
        case (m)
            7'd2:                     month_len = (y[1:0] == 2'd0) ? 7'd29 : 7'd28;
            7'd4, 7'd6, 7'd9, 7'd11:  month_len = 7'd30;
            default:                  month_len = 7'd31;
        endcase
    endfunction

endpackage

// File: rtl/calclk_seq.sv
module calclk_seq
    import calclk_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   tick,
    input  logic   hold,
    input  logic   carry,
    output stage_e stage,
    output logic   busy
);

    logic pending;
    logic start;

    assign start = (stage == ST_IDLE) && !hold && (tick || pending);
    assign busy  = (stage != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            stage   <= ST_IDLE;
            pending <= 1'b0;
        end else begin
            pending <= (pending || tick) && !start;
            case (stage)
                ST_IDLE: if (start) stage <= ST_SEC;
                ST_SEC:  stage <= carry ? ST_MIN  : ST_IDLE;
                ST_MIN:  stage <= carry ? ST_HOUR : ST_IDLE;
                ST_HOUR: stage <= carry ? ST_DAY  : ST_IDLE;
                ST_DAY:  stage <= carry ? ST_MON  : ST_IDLE;
                ST_MON:  stage <= carry ? ST_YEAR : ST_IDLE;
                default: stage <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/calclk_fields.sv
module calclk_fields
    import calclk_pkg::*;
(
    input  logic              clk,
    input  stage_e            stage,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              carry,
    output logic              mode24,
    output cal_t              cal
);

    logic [6:0] sec_n, min_n;
    logic [5:0] hour_n, day_n;
    logic       pm_n;
    logic [4:0] mon_n;
    logic [7:0] year_n;
    logic [2:0] wday_n;
    logic       sec_w, min_w, hour_w, day_w, mon_w;

    always_comb begin
        sec_w  = (cal.sec == 7'h59);
        sec_n  = sec_w ? 7'h00 : bcd_inc({1'b0, cal.sec})[6:0];
        min_w  = (cal.min == 7'h59);
        min_n  = min_w ? 7'h00 : bcd_inc({1'b0, cal.min})[6:0];

        pm_n   = cal.pm;
        hour_w = 1'b0;
        if (mode24) begin
            hour_w = (cal.hour == 6'h23);
            hour_n = hour_w ? 6'h00 : bcd_inc({2'b00, cal.hour})[5:0];
        end else if (cal.hour == 6'h12) begin
            hour_n = 6'h01;
        end else if (cal.hour == 6'h11) begin
            hour_n = 6'h12;
            pm_n   = !cal.pm;
            hour_w = cal.pm;
        end else begin
            hour_n = bcd_inc({2'b00, cal.hour})[5:0];
        end

        day_w  = (bcd2bin({2'b00, cal.day}) >= month_len(cal.mon, cal.year));
        day_n  = day_w ? 6'h01 : bcd_inc({2'b00, cal.day})[5:0];
        wday_n = (cal.wday >= 3'd6) ? 3'd0 : cal.wday + 3'd1;
        mon_w  = (bcd2bin({3'd0, cal.mon}) >= 7'd12);
        mon_n  = mon_w ? 5'h01 : bcd_inc({3'd0, cal.mon})[4:0];
        year_n = (cal.year == 8'h99) ? 8'h00 : bcd_inc(cal.year);

        case (stage)
            ST_SEC:  carry = sec_w;
            ST_MIN:  carry = min_w;
            ST_HOUR: carry = hour_w;
            ST_DAY:  carry = day_w;
            ST_MON:  carry = mon_w;
            default: carry = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (stage == ST_IDLE) begin
            if (wr_en) begin
                case (wr_addr)
                    A_SEC:   cal.sec  <= wr_data[6:0];
                    A_MIN:   cal.min  <= wr_data[6:0];
                    A_HOUR:  begin
                        cal.hour <= wr_data[5:0];
                        cal.pm   <= wr_data[6];
                    end
                    A_DAY:   cal.day  <= wr_data[5:0];
                    A_MON:   cal.mon  <= wr_data[4:0];
                    A_YEAR:  cal.year <= wr_data;
                    A_WDAY:  cal.wday <= wr_data[2:0];
                    default: mode24   <= wr_data[0];
                endcase
            end
        end else begin
            case (stage)
                ST_SEC:  cal.sec  <= sec_n;
                ST_MIN:  cal.min  <= min_n;
                ST_HOUR: begin
                    cal.hour <= hour_n;
                    cal.pm   <= pm_n;
                end
                ST_DAY:  begin
                    cal.day  <= day_n;
                    cal.wday <= wday_n;
                end
                ST_MON:  cal.mon  <= mon_n;
                default: cal.year <= year_n;
            endcase
        end
    end

    always_comb begin
        case (rd_addr)
            A_SEC:   rd_data = {1'b0, cal.sec};
            A_MIN:   rd_data = {1'b0, cal.min};
            A_HOUR:  rd_data = {1'b0, cal.pm, cal.hour};
            A_DAY:   rd_data = {2'b00, cal.day};
            A_MON:   rd_data = {3'b000, cal.mon};
            A_YEAR:  rd_data = cal.year;
            A_WDAY:  rd_data = {5'd0, cal.wday};
            default: rd_data = {7'd0, mode24};
        endcase
    end

endmodule

// File: rtl/bcd_calendar_clock.sv
module bcd_calendar_clock
    import calclk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_1hz,
    input  logic              hold,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              busy
);

    stage_e stage;
    logic   carry;
    logic   mode24;
    cal_t   cal;

    calclk_seq u_seq (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick_1hz),
        .hold  (hold),
        .carry (carry),
        .stage (stage),
        .busy  (busy)
    );

    calclk_fields u_fields (
        .clk     (clk),
        .stage   (stage),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .carry   (carry),
        .mode24  (mode24),
        .cal     (cal)
    );

endmodule

// File: rtl/calclk_chk.sv
module calclk_chk
    import calclk_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       tick_1hz,
    input logic       hold,
    input logic       busy,
    input logic       wr_en,
    input logic       mode24,
    input logic [6:0] sec
);

    logic [2:0] run;

    always_ff @(posedge clk) begin
        if (rst) run <= 3'd0;
        else     run <= busy ? run + 3'd1 : 3'd0;
    end

    // R9
    hold_blocks_start_chk: assert property (@(posedge clk) disable iff (rst)
        (hold && !busy) |=> !busy);

    // R7
    tick_raises_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (tick_1hz && !hold && !busy) |=> busy);

    // R7
    ripple_bounded_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> (run < 3'(MAX_RIPPLE)));

    // R8
    blocked_write_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && wr_en) |=> $stable(mode24));

    // R9
    idle_sec_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !wr_en) |=> $stable(sec));

endmodule

bind bcd_calendar_clock calclk_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .tick_1hz (tick_1hz),
    .hold     (hold),
    .busy     (busy),
    .wr_en    (wr_en),
    .mode24   (mode24),
    .sec      (cal.sec)
);

// File: tb/bcd_calendar_clock_test.sv
module bcd_calendar_clock_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_1hz = 1'b0;
    logic       hold = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = 3'd0;
    logic [7:0] wr_data = 8'd0;
    logic [2:0] rd_addr = 3'd0;
    logic [7:0] rd_data;
    logic       busy;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    bcd_calendar_clock uut (
        .clk(clk), .rst(rst), .tick_1hz(tick_1hz), .hold(hold),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy)
    );

    function automatic int bcd(int v);
        return (v / 10) * 16 + (v % 10);
    endfunction

    function automatic int dim(int m, int y);
        if (m == 2) return (y % 4 == 0) ? 29 : 28;
        if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
        return 31;
    endfunction

    task automatic check(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(int a, int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'(a); wr_data = 8'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(int a, output int d);
        @(negedge clk);
        rd_addr = 3'(a);
        #1 d = int'(rd_data);
    endtask

    task automatic wait_idle(output int nb);
        nb = 0;
        while (busy && nb < 20) begin
            nb++;
            @(negedge clk);
        end
    endtask

    task automatic pulse(output int nb);
        @(negedge clk) tick_1hz = 1'b1;
        @(negedge clk) tick_1hz = 1'b0;
        wait_idle(nb);
    endtask

    task automatic set_all(int s, int mi, int h, int d, int mo, int y, int w);
        wr(0, s); wr(1, mi); wr(2, h); wr(3, d); wr(4, mo); wr(5, y); wr(6, w);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int v, nb, nxt, h12, pm, ln, y;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R10 busy after reset", int'(busy), 0);

        wr(7, 1);
        rd(7, v); check("R11 control readback", v, 1);
        set_all(0, 0, 0, 1, 1, 0, 0);
        rd(2, v); check("R11 hour readback", v, 0);

        // R1 seconds sweep, plain advance is one busy cycle (R7)
        for (int i = 1; i <= 60; i++) begin
            pulse(nb);
            rd(0, v); check("R1 seconds", v, bcd(i % 60));
            if (i == 1) check("R7 busy seconds only", nb, 1);
            if (i == 60) check("R7 busy seconds+minutes", nb, 2);
        end
        rd(1, v); check("R1 minute carry", v, 1);
        wr(0, 'h59); wr(1, 'h59); wr(2, 'h05);
        pulse(nb);
        rd(1, v); check("R1 minute wrap", v, 0);
        rd(2, v); check("R1 hour carry", v, 6);

        // R2 24-hour sweep
        for (int h = 0; h < 24; h++) begin
            set_all('h59, 'h59, bcd(h), 'h10, 3, 5, 2);
            pulse(nb);
            rd(2, v); check("R2 hour 24", v, bcd((h + 1) % 24));
            rd(3, v); check("R2 day carry", v, (h == 23) ? 'h11 : 'h10);
        end

        // R3 12-hour sweep, index 0 is 12 at night
        wr(7, 0);
        for (int s = 0; s < 24; s++) begin
            h12 = (s % 12 == 0) ? 12 : s % 12;
            pm = (s >= 12) ? 1 : 0;
            set_all('h59, 'h59, pm * 64 + bcd(h12), 'h10, 3, 5, 2);
            pulse(nb);
            nxt = (s + 1) % 24;
            h12 = (nxt % 12 == 0) ? 12 : nxt % 12;
            pm = (nxt >= 12) ? 1 : 0;
            rd(2, v); check("R3 hour 12", v, pm * 64 + bcd(h12));
            rd(3, v); check("R3 day carry", v, (s == 23) ? 'h11 : 'h10);
        end
        wr(7, 1);

        // R4 R5 R6 month ends across common, leap and final years
        for (int yy = 0; yy < 5; yy++) begin
            y = (yy == 4) ? 99 : yy;
            for (int m = 1; m <= 12; m++) begin
                ln = dim(m, y);
                set_all('h59, 'h59, 'h23, bcd(ln), bcd(m), bcd(y), m % 7);
                pulse(nb);
                rd(3, v); check("R4 day wrap", v, 1);
                rd(4, v); check("R5 month", v, bcd((m == 12) ? 1 : m + 1));
                rd(5, v); check("R5 year", v, bcd((m == 12) ? (y + 1) % 100 : y));
                rd(6, v); check("R6 weekday", v, (m % 7 + 1) % 7);
                check("R7 busy depth", nb, (m == 12) ? 6 : 5);
            end
            set_all('h59, 'h59, 'h23, 'h28, 2, bcd(y), 6);
            pulse(nb);
            rd(3, v); check("R4 feb 28 step", v, (y % 4 == 0) ? 'h29 : 1);
            rd(6, v); check("R6 weekday wrap", v, 0);
        end

        // R4 out-of-calendar days
        set_all('h59, 'h59, 'h23, 'h31, 4, 'h20, 0);
        pulse(nb);
        rd(3, v); check("R4 april 31 day", v, 1);
        rd(4, v); check("R4 april 31 month", v, 5);
        set_all('h59, 'h59, 'h23, 'h29, 2, 'h06, 0);
        pulse(nb);
        rd(3, v); check("R4 feb 29 common day", v, 1);
        rd(4, v); check("R4 feb 29 common month", v, 3);

        // R8 write while busy
        wr(1, 'h20); wr(0, 'h10);
        @(negedge clk) tick_1hz = 1'b1;
        @(negedge clk) tick_1hz = 1'b0;
        check("R8 busy present", int'(busy), 1);
        wr_en = 1'b1; wr_addr = 3'd1; wr_data = 8'h45;
        @(negedge clk) wr_en = 1'b0;
        wait_idle(nb);
        rd(1, v); check("R8 minute untouched", v, 'h20);
        rd(0, v); check("R8 seconds advanced", v, 'h11);

        // R9 hold with several pulses
        @(negedge clk) hold = 1'b1;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk) tick_1hz = 1'b1;
            @(negedge clk) tick_1hz = 1'b0;
            check("R9 no busy in hold", int'(busy), 0);
        end
        rd(0, v); check("R9 frozen in hold", v, 'h11);
        @(negedge clk) hold = 1'b0;
        @(negedge clk);
        check("R9 deferred start", int'(busy), 1);
        wait_idle(nb);
        repeat (3) @(negedge clk);
        rd(0, v); check("R9 single advance", v, 'h12);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule